// File: doc/BRIEF.md
# Three-Wire Serial Command Slave

This block is the slave end of a half-duplex serial control port that has three wires: an active-low frame enable, a serial clock driven by the master, and one shared data line. It runs entirely in a faster system clock. The frame enable, the serial clock and the data line are each brought in through two-flop synchronisers, and the edges of the serial clock are found by comparing successive synchronised samples. The system clock must run at least eight times faster than the serial clock.

Every frame begins with an eight-bit control byte, sent most significant bit first. Its top bit sets the direction. The seven bits below it form an opcode, which is presented beside the frame's data. In a write frame the master then sends 64 data bits, MSB first. The block delivers them as one 64-bit command word, together with a single-cycle strobe. In a read frame the block takes a snapshot of a 128-bit reply buffer when the control byte completes. Both sides then leave the line undriven for one serial clock period. After that the block shifts the reply out, MSB first, and changes the line on falling edges of the serial clock. Deasserting the frame enable ends a frame at any point.

Top module: `spi3w_cmd_slave`

## Requirements
- R1: While reset is asserted and just after it, `sdioOe`, `cmdValid` and `readStrobe` are 0 and `cmdData` is all zeros.
- R2: If control bit 7 is 0, the 64 bits that follow form `cmdData`, with the first bit received landing in bit 63. `cmdOpcode` carries control bits 6..0. `cmdValid` is high for exactly one system clock.
- R3: A write frame that ends before its 64th data bit produces no `cmdValid`, and `cmdData` keeps its previous value.
- R4: If control bit 7 is 1, `readStrobe` pulses for one system clock, `cmdOpcode` carries control bits 6..0, and `replyData` is captured at that moment. Later changes to `replyData` do not affect the frame.
- R5: `sdioOe` stays 0 through the control byte and through the serial clock period that follows it, which is the turnaround.
- R6: In a read frame, on serial rising edges 10 to 137 of the frame, `sdioOe` is 1 and `sdioOut` carries captured reply bits 127 down to 0, in that order.
- R7: The falling edge that follows the rising edge carrying the last reply bit sets `sdioOe` to 0, and it stays 0 for any further clocks in that frame.
- R8: Deasserting `senN` at any point clears `sdioOe` within four system clocks and resets all counters, so the next frame decodes from its first bit.
- R9: Serial clocks after the 64th data bit of a write frame produce no further strobe and leave `cmdData` unchanged.
- R10: While the block drives the line, `sdioOut` changes only in response to a falling edge of the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| senN | input | 1 | Frame enable from master, active low, asynchronous |
| sclk | input | 1 | Serial clock from master, asynchronous |
| sdioIn | input | 1 | Value seen on the shared data line |
| sdioOut | output | 1 | Value the slave drives onto the data line |
| sdioOe | output | 1 | Output enable for the data line pad |
| replyData | input | 128 | Reply buffer, bit 127 sent first |
| readStrobe | output | 1 | One-cycle pulse when a read control byte completes |
| cmdValid | output | 1 | One-cycle pulse when a 64-bit command word is complete |
| cmdOpcode | output | 7 | Control bits 6..0 of the latest frame |
| cmdData | output | 64 | Last complete command word |

## Verification
The bench targets write frames cut short and write frames overrun with extra clocks. A counter that is off by one either strobes on a short frame or latches a wrong extra bit instead of the first 64. It watches the turnaround and the release point on the line, where a slave that drives one clock early contends with the master and one that releases late holds the bus after the frame. It also changes the reply buffer in the middle of a read, which exposes a design that shifts live data instead of the snapshot. It aborts frames during the control byte and during read data, because counters that are not cleared on abort garble the frame that follows.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

  // Strobes from the sequencer to the datapath, valid for one system clock.
  typedef struct packed {
    logic abort;        // frame inactive: release the line
    logic shiftIn;      // sample the synchronised data bit
    logic ctrlCapture;  // control byte complete
    logic wrFire;       // last write bit arriving
    logic rdStart;      // first read bit: enable the driver
    logic rdShift;      // advance to the next read bit
    logic rdRelease;    // read data exhausted: release the line
  } dpCmd_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CTRL,
    S_WRITE,
    S_TURN,
    S_READ,
    S_HOLD
  } seqState_t;

endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[s] <= RESET_VAL;
        else       stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[s] <= RESET_VAL;
        else       stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/spi3w_ctrl.sv
module spi3w_ctrl
  import spi3w_pkg::*;
#(
  parameter int unsigned CTRL_BITS = 8,
  parameter int unsigned WR_BITS = 64,
  parameter int unsigned RD_BITS = 128
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   frameActive,
  input  logic   sclkRise,
  input  logic   sclkFall,
  input  logic   dirRead,
  output dpCmd_t cmd
);

  localparam int unsigned MAX_BITS = (RD_BITS > WR_BITS) ? RD_BITS : WR_BITS;
  localparam int unsigned CW = $clog2(MAX_BITS + 1);
  localparam logic [CW-1:0] CTRL_LAST = CW'(CTRL_BITS - 1);
  localparam logic [CW-1:0] WR_LAST = CW'(WR_BITS - 1);
  localparam logic [CW-1:0] RD_END = CW'(RD_BITS);

  seqState_t state, stateNext;
  logic [CW-1:0] bitCnt, bitCntNext;

  always_comb begin
    cmd = '0;
    stateNext = state;
    bitCntNext = bitCnt;
    if (!frameActive) begin
      cmd.abort = 1'b1;
      stateNext = S_IDLE;
      bitCntNext = '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          stateNext = S_CTRL;
          bitCntNext = '0;
        end
        S_CTRL: begin
          if (sclkRise) begin
            cmd.shiftIn = 1'b1;
            if (bitCnt == CTRL_LAST) begin
              cmd.ctrlCapture = 1'b1;
              bitCntNext = '0;
              stateNext = dirRead ? S_TURN : S_WRITE;
            end else begin
              bitCntNext = bitCnt + 1'b1;
            end
          end
        end
        S_WRITE: begin
          if (sclkRise) begin
            cmd.shiftIn = 1'b1;
            if (bitCnt == WR_LAST) begin
              cmd.wrFire = 1'b1;
              stateNext = S_HOLD;
            end else begin
              bitCntNext = bitCnt + 1'b1;
            end
          end
        end
        S_TURN: begin
          if (sclkRise) begin
            stateNext = S_READ;
            bitCntNext = '0;
          end
        end
        S_READ: begin
          if (sclkFall) begin
            if (bitCnt == '0) begin
              cmd.rdStart = 1'b1;
              bitCntNext = bitCnt + 1'b1;
            end else if (bitCnt == RD_END) begin
              cmd.rdRelease = 1'b1;
              stateNext = S_HOLD;
            end else begin
              cmd.rdShift = 1'b1;
              bitCntNext = bitCnt + 1'b1;
            end
          end
        end
        default: begin
          stateNext = S_HOLD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      bitCnt <= '0;
    end else begin
      state <= stateNext;
      bitCnt <= bitCntNext;
    end
  end

endmodule

// File: rtl/spi3w_datapath.sv
module spi3w_datapath
  import spi3w_pkg::*;
#(
  parameter int unsigned CTRL_BITS = 8,
  parameter int unsigned WR_BITS = 64,
  parameter int unsigned RD_BITS = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCmd_t               cmd,
  input  logic                 serBit,
  input  logic [RD_BITS-1:0]   replyData,
  output logic                 dirRead,
  output logic [WR_BITS-1:0]   cmdData,
  output logic [CTRL_BITS-2:0] cmdOpcode,
  output logic                 cmdValid,
  output logic                 readStrobe,
  output logic                 sdioOut,
  output logic                 sdioOe
);

  localparam int unsigned OP_W = CTRL_BITS - 1;

  logic [WR_BITS-2:0] inSr;
  logic [RD_BITS-1:0] outSr;
  logic               oeReg;

  // The first control bit sits just above the opcode bits once the
  // last control bit is on the wire.
  assign dirRead = inSr[OP_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSr <= '0;
      outSr <= '0;
      oeReg <= 1'b0;
      cmdData <= '0;
      cmdOpcode <= '0;
      cmdValid <= 1'b0;
      readStrobe <= 1'b0;
    end else begin
      cmdValid <= cmd.wrFire;
      readStrobe <= cmd.ctrlCapture & dirRead;
      if (cmd.shiftIn) inSr <= {inSr[WR_BITS-3:0], serBit};
      if (cmd.ctrlCapture) begin
        cmdOpcode <= {inSr[OP_W-2:0], serBit};
        if (dirRead) outSr <= replyData;
      end
      if (cmd.wrFire) cmdData <= {inSr, serBit};
      if (cmd.rdShift) outSr <= {outSr[RD_BITS-2:0], 1'b0};
      if (cmd.abort || cmd.rdRelease) oeReg <= 1'b0;
      else if (cmd.rdStart) oeReg <= 1'b1;
    end
  end

  assign sdioOe = oeReg;
  assign sdioOut = oeReg & outSr[RD_BITS-1];

endmodule

// File: rtl/spi3w_cmd_slave.sv
module spi3w_cmd_slave
  import spi3w_pkg::*;
#(
  parameter int unsigned CTRL_BITS = 8,
  parameter int unsigned WR_BYTES = 8,
  parameter int unsigned RD_BYTES = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WR_BITS = WR_BYTES * 8,
  localparam int unsigned RD_BITS = RD_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 senN,
  input  logic                 sclk,
  input  logic                 sdioIn,
  output logic                 sdioOut,
  output logic                 sdioOe,
  input  logic [RD_BITS-1:0]   replyData,
  output logic                 readStrobe,
  output logic                 cmdValid,
  output logic [CTRL_BITS-2:0] cmdOpcode,
  output logic [WR_BITS-1:0]   cmdData
);

  // Synchronised pins: [2] frame enable (idles high), [1] clock, [0] data.
  logic [2:0] pinSync;
  logic       sclkPrev;
  logic       frameActive;
  logic       sclkRise;
  logic       sclkFall;
  logic       dirRead;
  dpCmd_t     dpCmd;

  spi3w_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(3'b100)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({senN, sclk, sdioIn}),
    .dout(pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= pinSync[1];
  end

  assign frameActive = ~pinSync[2];
  assign sclkRise = pinSync[1] & ~sclkPrev;
  assign sclkFall = ~pinSync[1] & sclkPrev;

  spi3w_ctrl #(
    .CTRL_BITS(CTRL_BITS),
    .WR_BITS(WR_BITS),
    .RD_BITS(RD_BITS)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameActive(frameActive),
    .sclkRise   (sclkRise),
    .sclkFall   (sclkFall),
    .dirRead    (dirRead),
    .cmd        (dpCmd)
  );

  spi3w_datapath #(
    .CTRL_BITS(CTRL_BITS),
    .WR_BITS(WR_BITS),
    .RD_BITS(RD_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (dpCmd),
    .serBit    (pinSync[0]),
    .replyData (replyData),
    .dirRead   (dirRead),
    .cmdData   (cmdData),
    .cmdOpcode (cmdOpcode),
    .cmdValid  (cmdValid),
    .readStrobe(readStrobe),
    .sdioOut   (sdioOut),
    .sdioOe    (sdioOe)
  );

endmodule

// File: rtl/spi3w_cmd_slave_chk.sv
module spi3w_cmd_slave_chk (
  input logic clk,
  input logic rstN,
  input logic sdioOe,
  input logic sdioOut,
  input logic cmdValid,
  input logic readStrobe,
  input logic frameActive,
  input logic sclkFall
);

  // R1: reset leaves the port quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!sdioOe && !cmdValid && !readStrobe));

  // R2: command strobe lasts one clock
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R4: read strobe lasts one clock
  p_read_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe |=> !readStrobe);

  // R8: an inactive frame releases the line on the next clock
  p_release_on_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |=> !sdioOe);

  // R8: the driver is only on after a clock with the frame active
  p_drive_in_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    sdioOe |-> $past(frameActive));

  // R10: driven data moves only after a serial falling edge
  p_out_on_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sdioOe && $past(sdioOe) && !$stable(sdioOut)) |-> $past(sclkFall));

endmodule

bind spi3w_cmd_slave spi3w_cmd_slave_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sdioOe     (sdioOe),
  .sdioOut    (sdioOut),
  .cmdValid   (cmdValid),
  .readStrobe (readStrobe),
  .frameActive(frameActive),
  .sclkFall   (sclkFall)
);

// File: tb/spi3w_cmd_slave_tb.sv
module spi3w_cmd_slave_tb;

  logic         clk = 1'b0;
  logic         rstN;
  logic         senN = 1'b1;
  logic         sclk = 1'b0;
  logic         mDrv = 1'b1;
  logic         mOe = 1'b0;
  logic         sdioIn;
  logic         sdioOut;
  logic         sdioOe;
  logic [127:0] replyData = '0;
  logic         readStrobe;
  logic         cmdValid;
  logic [6:0]   cmdOpcode;
  logic [63:0]  cmdData;

  int checks = 0;
  int errors = 0;

  logic [70:0] expWr[$];
  logic [6:0]  expRd[$];
  logic [63:0] lastData = '0;

  always #10 clk = ~clk;

  // Shared line: master, slave, or pull-up.
  always_comb sdioIn = mOe ? mDrv : (sdioOe ? sdioOut : 1'b1);

  spi3w_cmd_slave u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .senN      (senN),
    .sclk      (sclk),
    .sdioIn    (sdioIn),
    .sdioOut   (sdioOut),
    .sdioOe    (sdioOe),
    .replyData (replyData),
    .readStrobe(readStrobe),
    .cmdValid  (cmdValid),
    .cmdOpcode (cmdOpcode),
    .cmdData   (cmdData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Per-clock comparison against the expected event queues.
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (cmdValid) begin
        if (expWr.size() == 0) check(1'b0, "R3", "unexpected command strobe", 1, 0);
        else begin
          logic [70:0] e;
          e = expWr.pop_front();
          check({cmdOpcode, cmdData} == e, "R2", "command word", {cmdOpcode, cmdData}, e);
        end
      end
      if (readStrobe) begin
        if (expRd.size() == 0) check(1'b0, "R4", "unexpected read strobe", 1, 0);
        else begin
          logic [6:0] o;
          o = expRd.pop_front();
          check(cmdOpcode == o, "R4", "read opcode", cmdOpcode, o);
        end
      end
      if (sdioOe && mOe) check(1'b0, "R5", "line contention", 1, 0);
    end
  end

  task automatic sendBit(input logic b);
    mOe = 1'b1;
    mDrv = b;
    #200 sclk = 1'b1;
    #200 sclk = 1'b0;
  endtask

  task automatic sendCtrl(input logic rd, input logic [6:0] op);
    logic [7:0] c;
    c = {rd, op};
    senN = 1'b0;
    #200;
    for (int i = 7; i >= 0; i--) sendBit(c[i]);
  endtask

  task automatic endFrame();
    #200;
    mOe = 1'b0;
    senN = 1'b1;
    #400;
  endtask

  task automatic writeFrame(input logic [6:0] op, input logic [63:0] d,
                            input int nBits);
    if (nBits >= 64) begin
      expWr.push_back({op, d});
    end
    sendCtrl(1'b0, op);
    for (int i = 0; i < nBits; i++) sendBit(i < 64 ? d[63-i] : i[0]);
    endFrame();
    if (nBits >= 64) lastData = d;
  endtask

  task automatic readFrame(input logic [6:0] op, input logic [127:0] reply,
                           input int nBits);
    replyData = reply;
    expRd.push_back(op);
    sendCtrl(1'b1, op);
    mOe = 1'b0;
    // turnaround period
    #200;
    check(sdioOe == 1'b0, "R5", "driver during turnaround", sdioOe, 0);
    replyData = ~reply;
    sclk = 1'b1;
    #200 sclk = 1'b0;
    for (int k = 0; k < nBits; k++) begin
      #200;
      check(sdioOe == 1'b1, "R6", "driver enable", sdioOe, 1);
      check(sdioOut == reply[127-k], "R6", "read bit", sdioOut, reply[127-k]);
      sclk = 1'b1;
      #100;
      check(sdioOut == reply[127-k], "R10", "bit held past rise", sdioOut, reply[127-k]);
      #100 sclk = 1'b0;
    end
    if (nBits == 128) begin
      #200;
      check(sdioOe == 1'b0, "R7", "release after last bit", sdioOe, 0);
      sclk = 1'b1;
      #200 sclk = 1'b0;
      #200;
      check(sdioOe == 1'b0, "R7", "stays released", sdioOe, 0);
      senN = 1'b1;
      #400;
    end else begin
      senN = 1'b1;
      #100;
      check(sdioOe == 1'b0, "R8", "release on abort", sdioOe, 0);
      #300;
    end
  endtask

  initial begin : watchdog
    #3_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    rstN = 1'b0;
    #95;
    check(sdioOe == 1'b0, "R1", "oe in reset", sdioOe, 0);
    check(cmdValid == 1'b0, "R1", "strobe in reset", cmdValid, 0);
    check(readStrobe == 1'b0, "R1", "read strobe in reset", readStrobe, 0);
    check(cmdData == '0, "R1", "data in reset", cmdData, 0);
    rstN = 1'b1;
    #108;
    check(sdioOe == 1'b0 && cmdValid == 1'b0, "R1", "quiet after reset",
          {sdioOe, cmdValid}, 0);

    // R2: two write patterns
    writeFrame(7'h15, 64'h0123_4567_89AB_CDEF, 64);
    check(cmdData == lastData, "R2", "held data", cmdData, lastData);
    writeFrame(7'h7F, 64'hA5A5_FFFF_0000_5A5A, 64);
    check(cmdData == lastData, "R2", "held data", cmdData, lastData);

    // R3: short write leaves data alone
    writeFrame(7'h2A, 64'hDEAD_BEEF_CAFE_F00D, 40);
    check(cmdData == lastData, "R3", "data after short frame", cmdData, lastData);

    // R9: overrun write
    writeFrame(7'h01, 64'hFEDC_BA98_7654_3210, 70);
    check(cmdData == lastData, "R9", "data after extra clocks", cmdData, lastData);

    // R4, R5, R6, R7, R10: full reads
    readFrame(7'h42, 128'h8123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6979, 128);
    readFrame(7'h00, 128'h5555_AAAA_0000_FFFF_1248_8421_C3C3_3C3D, 128);

    // R8: abort a read mid-data, then a write decodes cleanly
    readFrame(7'h33, 128'hFFFF_0000_FFFF_0000_1234_5678_9ABC_DEF0, 20);
    writeFrame(7'h0C, 64'h1111_2222_3333_4444, 64);
    check(cmdData == lastData, "R8", "write after aborted read", cmdData, lastData);

    // R8: abort inside the control byte
    senN = 1'b0;
    #200;
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    endFrame();
    check(sdioOe == 1'b0, "R8", "oe after control abort", sdioOe, 0);
    writeFrame(7'h55, 64'h0F0F_0F0F_F0F0_F0F0, 64);
    check(cmdData == lastData, "R8", "write after control abort", cmdData, lastData);

    #400;
    check(expWr.size() == 0, "R2", "missing command strobes", expWr.size(), 0);
    check(expRd.size() == 0, "R4", "missing read strobes", expRd.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule